// File: doc/BRIEF.md
# Conversion Result Readout Serializer

This block is the read side of a SPI-style slave that returns stored converter results. It keeps a one-entry holding register for the most recent temperature code and reads the head of a result FIFO that sits outside the block. At the start of every 16-bit word slot it picks a source. A pending temperature code goes first. If no temperature code is pending, the FIFO head is used. If the FIFO is also empty, the word is all zeros. Every 12-bit result is widened to 16 bits with four zero bits on top and shifted out MSB first, two bytes per result.

The serial pins are sampled into the block's system clock domain, so SCLK must run well below the system clock. The master works in SPI mode 0: SCLK idles low, the master samples on the rising SCLK edge, and the block moves to the next bit on the falling edge. A source is consumed only when the whole word has been sampled. A FIFO entry is then popped, or the temperature flag is cleared. Deasserting chip select partway through a word leaves the source untouched. Several words can be read back to back inside one chip-select frame.

Top module: `rr_readout_serializer`

## Requirements
- R1: After reset `spi_dout` is 0 and `fifo_pop` is 0. `fifo_pop` is never high for two cycles in a row.
- R2: While chip select is high, `spi_dout` is 0.
- R3: A FIFO result v is sent as the 16-bit word {4'b0000, v}, MSB first. The bit the master samples on rising SCLK edge n (n = 1..16 within the word) is bit 16−n of that word.
- R4: When the FIFO is empty and no temperature code is pending, the word reads as 16 zero bits and no pop is issued. A pop is only ever issued while the FIFO is non-empty.
- R5: A pending temperature code t is sent before any FIFO data, as {4'b0000, t}. The 12-bit code is two's complement at 8 LSB per degree and is passed through unchanged.
- R6: A temperature code written while an earlier one is still unread replaces the earlier one. Only the newest value is returned.
- R7: The temperature pending flag clears only after all 16 bits of a temperature word have been sampled. The following word then comes from the FIFO.
- R8: Exactly one single-cycle `fifo_pop` follows each fully sampled FIFO word. It is issued after the word's 16th rising SCLK edge and before the next falling edge.
- R9: If chip select rises before a word's 16th rising edge, nothing is consumed. The same FIFO entry or temperature code is returned again in full by the next frame.
- R10: A temperature write that lands at any time after the temperature word was loaded, including the cycle in which that word completes, keeps the pending flag set. The new value is returned by the next word.
- R11: Within one chip-select frame, consecutive 16-bit words are sent without gaps, each with its own source choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select from master, active low (asynchronous) |
| spi_sclk | input | 1 | Serial clock from master, idles low (asynchronous) |
| spi_dout | output | 1 | Serial data to master, registered |
| fifo_empty | input | 1 | Result FIFO has no entries |
| fifo_data | input | 12 | Result at the FIFO head, valid while not empty |
| fifo_pop | output | 1 | One-cycle strobe that removes the FIFO head |
| temp_wr | input | 1 | One-cycle strobe: a new temperature code is ready |
| temp_code | input | 12 | Temperature code, two's complement, 8 LSB per degree |

## Verification
The risky coincidence is a new temperature write landing in the same system cycle as the completion of the temperature word being read, which is when the pending flag would normally clear. The bench provokes this by sweeping the write strobe across every system-clock offset inside the final SCLK high phase of a temperature word. That sweep necessarily includes the completion cycle. At each offset it requires the next word to carry the newly written code and the word after it to carry FIFO data. Pop counts are compared after every frame, so a lost or doubled consume is caught at the same time.

// File: rtl/rr_pkg.sv
// Package: shared types of the readout serializer.
// Assumes nothing beyond IEEE 1800-2017.
package rr_pkg;

    // Which source filled the word currently being shifted out.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FIFO = 2'd1,
        SRC_TEMP = 2'd2
    } rr_src_e;

endpackage

// File: rtl/rr_edge_sync.sv
// Module: rr_edge_sync
// Brings N asynchronous levels into the clk domain with a two-flop
// synchronizer each, and reports the synchronized level plus one-cycle
// rise and fall pulses. Assumes every input is stable for at least
// three clk periods between changes.
module rr_edge_sync #(
    parameter int          N          = 2,
    parameter logic [N-1:0] RESET_LVL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic s1, s2, s3;

            // Two synchronizer stages plus one history stage per bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= RESET_LVL[g];
                    s2 <= RESET_LVL[g];
                    s3 <= RESET_LVL[g];
                end else begin
                    s1 <= async_in[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end

            // Edge pulses from the synchronized level and its history.
            always_comb begin
                level[g] = s2;
                rise[g]  = s2 & ~s3;
                fall[g]  = ~s2 & s3;
            end
        end
    endgenerate

endmodule

// File: rtl/rr_source_sel.sv
// Module: rr_source_sel
// Holds the single temperature result and picks the word to send next:
// a pending temperature code, else the FIFO head, else zero. Results are
// padded with leading zeros to the word width. When the shifter reports
// a fully sent word, the chosen source is consumed: the FIFO is popped,
// or the temperature flag is cleared unless a newer code arrived after
// the word was loaded. Assumes load and done never coincide.
module rr_source_sel
    import rr_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_wr,
    input  logic [RES_W-1:0]  temp_code,
    input  logic              fifo_empty,
    input  logic [RES_W-1:0]  fifo_data,
    input  logic              load,
    input  logic              done,
    output logic [WORD_W-1:0] word,
    output logic              fifo_pop,
    output logic              temp_valid
);

    localparam int PAD_W = WORD_W - RES_W;

    logic [RES_W-1:0] temp_q;
    logic             temp_dirty;
    rr_src_e          src_next;
    rr_src_e          src_q;

    // Priority choice of the next source and its padded word.
    always_comb begin
        if (temp_valid) begin
            src_next = SRC_TEMP;
            word     = {{PAD_W{1'b0}}, temp_q};
        end else if (!fifo_empty) begin
            src_next = SRC_FIFO;
            word     = {{PAD_W{1'b0}}, fifo_data};
        end else begin
            src_next = SRC_NONE;
            word     = '0;
        end
    end

    // Remember which source the word in flight came from.
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= SRC_NONE;
        else if (load)
            src_q <= src_next;
    end

    // Temperature register, pending flag, and newer-write marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q     <= '0;
            temp_valid <= 1'b0;
            temp_dirty <= 1'b0;
        end else if (temp_wr) begin
            temp_q     <= temp_code;
            temp_valid <= 1'b1;
            temp_dirty <= 1'b1;
        end else begin
            if (load && temp_valid)
                temp_dirty <= 1'b0;
            if (done && src_q == SRC_TEMP && !temp_dirty)
                temp_valid <= 1'b0;
        end
    end

    // One-cycle pop once a FIFO word has been fully sent.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fifo_pop <= 1'b0;
        else
            fifo_pop <= done && (src_q == SRC_FIFO);
    end

endmodule

// File: rtl/rr_shifter.sv
// Module: rr_shifter
// Parallel-in, serial-out register driven by synchronized SPI events.
// Loads a word when chip select becomes active and again on the first
// falling SCLK edge after each completed word. Advances one bit per
// falling edge and counts rising edges to flag a fully sampled word.
// Assumes SPI mode 0 (SCLK idle low). The output is forced low while
// chip select is inactive.
module rr_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              start,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic [WORD_W-1:0] word,
    output logic              load,
    output logic              done,
    output logic              dout
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              reload_q;

    // Load request at frame start or at the boundary after a word.
    always_comb load = start | (active & sclk_fall & reload_q);

    // Shift register: parallel load or one-bit advance on falling SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (load)
            shreg <= word;
        else if (active && sclk_fall)
            shreg <= {shreg[WORD_W-2:0], 1'b0};
    end

    // Rising-edge counter, word-boundary marker and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            reload_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active || start) begin
                cnt      <= '0;
                reload_q <= 1'b0;
            end else begin
                if (load)
                    reload_q <= 1'b0;
                if (sclk_rise) begin
                    if (cnt == LAST) begin
                        cnt      <= '0;
                        reload_q <= 1'b1;
                        done     <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    // Registered serial output, held low outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= 1'b0;
        else
            dout <= active ? shreg[WORD_W-1] : 1'b0;
    end

endmodule

// File: rtl/rr_readout_serializer.sv
// Module: rr_readout_serializer (top)
// Serial readout of converter results: a pending temperature code first,
// then FIFO entries, then zeros, each as a zero-padded word sent MSB
// first. SPI mode 0 slave whose pins are oversampled by clk. Assumes each
// SCLK phase lasts at least five clk periods and that the FIFO presents
// its head word while fifo_empty is low.
module rr_readout_serializer #(
    parameter int RES_W  = 12,
    parameter int WORD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_cs_n,
    input  logic             spi_sclk,
    output logic             spi_dout,
    input  logic             fifo_empty,
    input  logic [RES_W-1:0] fifo_data,
    output logic             fifo_pop,
    input  logic             temp_wr,
    input  logic [RES_W-1:0] temp_code
);

    logic [1:0]        pin_lvl, pin_rise, pin_fall;
    logic              cs_idle, cs_start, active;
    logic              word_load, word_done, temp_valid;
    logic [WORD_W-1:0] next_word;

    // Bit 0 is chip select (resets idle high), bit 1 is SCLK (idle low).
    rr_edge_sync #(.N(2), .RESET_LVL(2'b01)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_sclk, spi_cs_n}),
        .level    (pin_lvl),
        .rise     (pin_rise),
        .fall     (pin_fall)
    );

    // Frame state taken from the synchronized chip select.
    always_comb begin
        cs_idle  = pin_lvl[0];
        active   = ~pin_lvl[0];
        cs_start = pin_fall[0];
    end

    rr_source_sel #(.RES_W(RES_W), .WORD_W(WORD_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_wr    (temp_wr),
        .temp_code  (temp_code),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .load       (word_load),
        .done       (word_done),
        .word       (next_word),
        .fifo_pop   (fifo_pop),
        .temp_valid (temp_valid)
    );

    rr_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .start     (cs_start),
        .sclk_rise (pin_rise[1]),
        .sclk_fall (pin_fall[1]),
        .word      (next_word),
        .load      (word_load),
        .done      (word_done),
        .dout      (spi_dout)
    );

endmodule

// File: rtl/rr_readout_checker.sv
// Module: rr_readout_checker
// Temporal properties of the readout serializer, bound to the top.
module rr_readout_checker (
    input logic clk,
    input logic rst_n,
    input logic fifo_pop,
    input logic fifo_empty,
    input logic temp_wr,
    input logic spi_dout,
    input logic cs_idle,
    input logic word_done,
    input logic temp_valid
);

    // R1: the pop strobe lasts exactly one cycle.
    a_r1_pop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    // R2: the output is low in the cycle after chip select is seen idle.
    a_r2_dout_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !spi_dout);

    // R4: no pop is issued against an empty FIFO.
    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R8: a pop always follows a completed word.
    a_r8_pop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> $past(word_done));

    // R7: the temperature flag clears only on word completion.
    a_r7_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(temp_valid) |-> $past(word_done));

    // R10: a temperature write always leaves the flag set.
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        temp_wr |=> temp_valid);

endmodule

bind rr_readout_serializer rr_readout_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty),
    .temp_wr    (temp_wr),
    .spi_dout   (spi_dout),
    .cs_idle    (cs_idle),
    .word_done  (word_done),
    .temp_valid (temp_valid)
);

// File: tb/tb_rr_readout_serializer.sv
`timescale 1ns/1ps
module tb_rr_readout_serializer;

    localparam int H = 6; // SCLK half period in clk cycles

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_dout;
    logic        fifo_empty;
    logic [11:0] fifo_data;
    logic        fifo_pop;
    logic        temp_wr = 1'b0;
    logic [11:0] temp_code = '0;

    logic [11:0] fmem [0:63];
    int          head = 0;
    int          tail = 0;
    int          pops = 0;
    int          errors = 0;
    int          checks = 0;
    logic [15:0] got [0:7];

    always #4 clk = ~clk;

    // FIFO model: first-word-fall-through, popped by the design.
    assign fifo_empty = (head == tail);
    assign fifo_data  = fmem[head % 64];
    always @(posedge clk) if (rst_n && fifo_pop) begin
        head <= head + 1;
        pops <= pops + 1;
    end

    rr_readout_serializer dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_dout(spi_dout), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .temp_wr(temp_wr), .temp_code(temp_code)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] v);
        fmem[tail % 64] = v;
        tail = tail + 1;
    endtask

    task automatic twrite(input logic [11:0] v);
        temp_code = v;
        temp_wr   = 1'b1;
        tick(1);
        temp_wr   = 1'b0;
    endtask

    // One chip-select frame. nbits rising edges; optional temperature write
    // at clk offset wr_off within the last SCLK high phase.
    task automatic frame(input int nbits, input int wr_off, input logic [11:0] wr_val);
        for (int i = 0; i < 8; i++) got[i] = '0;
        spi_cs_n = 1'b0;
        tick(H);
        for (int n = 0; n < nbits; n++) begin
            got[n/16] = {got[n/16][14:0], spi_dout};
            spi_sclk = 1'b1;
            for (int j = 0; j < H; j++) begin
                if (n == nbits - 1 && j == wr_off) begin
                    temp_code = wr_val;
                    temp_wr   = 1'b1;
                end
                tick(1);
                temp_wr = 1'b0;
            end
            spi_sclk = 1'b0;
            tick(H);
        end
        spi_cs_n = 1'b1;
        tick(10);
    endtask

    initial begin
        int exp_pops;
        logic [11:0] v;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk("R1 dout after reset", spi_dout, 0);
        chk("R1 pop after reset", fifo_pop, 0);

        // R4: empty FIFO reads zero, no pop
        frame(16, -1, 0);
        chk("R4 empty word", got[0], 0);
        chk("R4 no pop", pops, 0);

        // R3/R8/R11: sweep values four per frame
        exp_pops = 0;
        for (int k = 0; k < 12; k++) begin
            for (int m = 0; m < 4; m++) begin
                case (k * 4 + m)
                    0: v = 12'h000;
                    1: v = 12'hFFF;
                    2: v = 12'h800;
                    3: v = 12'h7FF;
                    default: v = 12'((k * 4 + m) * 1237 + 5);
                endcase
                push(v);
            end
            frame(64, -1, 0);
            exp_pops += 4;
            for (int m = 0; m < 4; m++)
                chk("R3 R11 fifo word", got[m], {4'h0, fmem[(k * 4 + m) % 64]});
            chk("R8 pop count", pops, exp_pops);
        end

        // R2: with data queued and CS high, output stays low
        push(12'hA5C);
        for (int i = 0; i < 20; i++) begin
            tick(1);
            chk("R2 idle dout", spi_dout, 0);
        end

        // R9: abort mid-word keeps the FIFO entry
        frame(7, -1, 0);
        chk("R9 no pop on abort", pops, exp_pops);
        frame(16, -1, 0);
        exp_pops++;
        chk("R9 reread after abort", got[0], 16'h0A5C);
        chk("R9 pop after full word", pops, exp_pops);

        // R5/R6/R7: temperature first, overwrite, then FIFO
        push(12'h321);
        twrite(12'hF38);
        twrite(12'h0C8);
        frame(32, -1, 0);
        exp_pops++;
        chk("R6 R5 newest temperature first", got[0], 16'h00C8);
        chk("R7 fifo after temperature", got[1], 16'h0321);
        chk("R8 one pop", pops, exp_pops);

        // R9: abort of temperature word keeps it pending
        twrite(12'hF38);
        frame(10, -1, 0);
        frame(16, -1, 0);
        chk("R9 R5 negative temperature reread", got[0], 16'h0F38);
        frame(16, -1, 0);
        chk("R7 flag cleared", got[0], 16'h0000);

        // R10: write swept across the completion window of a temperature word
        for (int k = 0; k < H; k++) begin
            twrite(12'(12'h100 + k));
            push(12'(12'h500 + k));
            frame(16, k, 12'(12'h200 + k));
            chk("R10 old temperature sent", got[0], 16'(16'h0100 + k));
            chk("R10 no pop on temperature", pops, exp_pops);
            frame(32, -1, 0);
            exp_pops++;
            chk("R10 new temperature kept", got[0], 16'(16'h0200 + k));
            chk("R10 fifo follows", got[1], 16'(16'h0500 + k));
            chk("R8 pop count", pops, exp_pops);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule